// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a register-mapped controller for 28 general-purpose pins. A simple synchronous register bus gives software access to the pins. Through it, software can read the synchronized pin levels and choose the direction of each pin. It changes output values only by writing masks to separate set and clear registers, so updating one pin never disturbs the others. An alternate-function word is stored, read back and exported for a pin multiplexer outside the block.

Each pin input passes through a two-flop synchronizer. The synchronized value is compared with its previous sample to find rising and falling transitions. Per-pin enables select which transitions are recorded in a sticky status register, and software clears that register by writing ones. The status drives eleven dedicated interrupt lines for pins 0 to 10 and one shared line for pins 11 to 27.

The bus uses a word index rather than a byte offset. Register k sits at byte offset 4*k. Data is one bit per pin, and bit n belongs to pin n.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the direction, output latch, both edge enables, edge status and alternate-function registers all read zero. pin_oe, pin_out, altfn, irq_lo and irq_hi are all zero.
- R2: Reading word 0 returns each pin input delayed by two clock edges, whatever the pin's direction. Writes to word 0 change nothing.
- R3: Word 1 is a read/write direction register, where 1 means output. pin_oe equals this register.
- R4: Writing word 2 sets the output latch bit for every data bit written as 1 and leaves the other bits unchanged. Reading word 2 returns the latch.
- R5: Writing word 3 clears the output latch bit for every data bit written as 1 and leaves the other bits unchanged. Reading word 3 returns the latch. pin_out equals the latch.
- R6: Word 4 holds the rising-edge enables. A synchronized 0-to-1 transition on a pin whose enable is set sets that pin's status bit.
- R7: Word 5 holds the falling-edge enables. A synchronized 1-to-0 transition on a pin whose enable is set sets its status bit. With both enables set, either transition sets it.
- R8: Status bits (word 6) stay set until software writes 1 to them. Status bits written as 0 are unchanged.
- R9: When a new enabled transition arrives in the same cycle as a write of 1 to that status bit, the bit stays set.
- R10: irq_lo[n] equals status bit n for pins 0 to 10.
- R11: irq_hi is 1 exactly when any status bit of pins 11 to 27 is 1.
- R12: Word 7 is a read/write alternate-function register, and altfn equals it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 28 | Write data, one bit per pin |
| bus_rdata | output | 28 | Read data for the addressed register (combinational) |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output latch values |
| pin_oe | output | 28 | Output enables (direction register) |
| altfn | output | 28 | Alternate-function selection |
| irq_lo | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_hi | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a fresh enabled transition on the bit it clears. The pin change must arrive three edges before the write takes effect, because of the synchronizer and the previous-sample stage. The bench sets up that case on purpose by driving the pin change and then timing the status write two idle cycles later. It also generates random pin toggles against random register writes, so that these collisions happen by chance as well. A behavioural model built on a history queue of pin values is compared with every output on every cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int PIN_COUNT   = 28;
    localparam int DIRECT_IRQS = 11;
    localparam int SHARED_IRQS = PIN_COUNT - DIRECT_IRQS;
    localparam int WORD_AW     = 3;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    typedef enum logic [WORD_AW-1:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_ALT   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t latch;
        pin_vec_t rise_en;
        pin_vec_t fall_en;
        pin_vec_t alt;
    } ctrl_regs_t;

    typedef struct packed {
        pin_vec_t rise;
        pin_vec_t fall;
    } edge_evt_t;

    function automatic pin_vec_t write_mask(input logic we, input reg_sel_e sel,
                                            input reg_sel_e target, input pin_vec_t data);
        return (we && sel == target) ? data : '0;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_vec_t  pins_async,
    output pin_vec_t  level,
    output edge_evt_t edges
);
    pin_vec_t meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        level      = sync_q;
        edges.rise = sync_q & ~prev_q;
        edges.fall = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  reg_sel_e   sel,
    input  pin_vec_t   wdata,
    output ctrl_regs_t regs
);
    ctrl_regs_t regs_q;
    pin_vec_t   set_mask, clr_mask;

    assign set_mask = write_mask(we, sel, SEL_SET, wdata);
    assign clr_mask = write_mask(we, sel, SEL_CLR, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q.latch <= (regs_q.latch | set_mask) & ~clr_mask;
            if (we) begin
                case (sel)
                    SEL_DIR:  regs_q.dir     <= wdata;
                    SEL_RISE: regs_q.rise_en <= wdata;
                    SEL_FALL: regs_q.fall_en <= wdata;
                    SEL_ALT:  regs_q.alt     <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign regs = regs_q;

    // R4
    set_apply_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((regs_q.latch & $past(set_mask)) == $past(set_mask)));

    // R5
    clr_apply_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((regs_q.latch & $past(clr_mask)) == '0));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_DIR) |=> $stable(regs_q.dir));
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
    import gpio_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t edges,
    input  pin_vec_t  rise_en,
    input  pin_vec_t  fall_en,
    input  pin_vec_t  clr_mask,
    output pin_vec_t  status
);
    pin_vec_t status_q, hit;

    assign hit = (edges.rise & rise_en) | (edges.fall & fall_en);

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | hit;
    end

    assign status = status_q;

    // R6 R7 R9
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(hit)) == $past(hit)));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map
    import gpio_edge_pkg::*;
(
    input  pin_vec_t               status,
    output logic [DIRECT_IRQS-1:0] irq_direct,
    output logic                   irq_shared
);
    for (genvar i = 0; i < DIRECT_IRQS; i++) begin : g_direct
        assign irq_direct[i] = status[i];
    end

    assign irq_shared = |status[PIN_COUNT-1:DIRECT_IRQS];
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WORD_AW-1:0]     bus_addr,
    input  logic                   bus_we,
    input  logic [PIN_COUNT-1:0]   bus_wdata,
    output logic [PIN_COUNT-1:0]   bus_rdata,
    input  logic [PIN_COUNT-1:0]   pin_in,
    output logic [PIN_COUNT-1:0]   pin_out,
    output logic [PIN_COUNT-1:0]   pin_oe,
    output logic [PIN_COUNT-1:0]   altfn,
    output logic [DIRECT_IRQS-1:0] irq_lo,
    output logic                   irq_hi
);
    reg_sel_e   sel;
    pin_vec_t   level, status, stat_clr;
    edge_evt_t  edges;
    ctrl_regs_t regs;

    assign sel      = reg_sel_e'(bus_addr);
    assign stat_clr = write_mask(bus_we, sel, SEL_STAT, bus_wdata);

    gpio_in_sync u_sync (
        .clk(clk), .rst(rst), .pins_async(pin_in), .level(level), .edges(edges)
    );

    gpio_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata), .regs(regs)
    );

    gpio_edge_status u_stat (
        .clk(clk), .rst(rst), .edges(edges), .rise_en(regs.rise_en),
        .fall_en(regs.fall_en), .clr_mask(stat_clr), .status(status)
    );

    gpio_irq_map u_irq (
        .status(status), .irq_direct(irq_lo), .irq_shared(irq_hi)
    );

    always_comb begin
        case (sel)
            SEL_LEVEL:        bus_rdata = level;
            SEL_DIR:          bus_rdata = regs.dir;
            SEL_SET, SEL_CLR: bus_rdata = regs.latch;
            SEL_RISE:         bus_rdata = regs.rise_en;
            SEL_FALL:         bus_rdata = regs.fall_en;
            SEL_STAT:         bus_rdata = status;
            default:          bus_rdata = regs.alt;
        endcase
    end

    assign pin_out = regs.latch;
    assign pin_oe  = regs.dir;
    assign altfn   = regs.alt;

    // R11
    shared_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_hi) |-> ($past(edges.rise | edges.fall) != '0));
endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [27:0] bus_wdata = '0;
    logic [27:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe, altfn;
    logic [10:0] irq_lo;
    logic        irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [27:0] hist[$];
    logic [27:0] m_dir, m_lat, m_ren, m_fen, m_st, m_alt;

    always #2 clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .altfn(altfn),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input bit ok, input string tag, input logic [27:0] act,
                         input logic [27:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%07h expected=%07h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [27:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return hist[1];
            3'd1: return m_dir;
            3'd2, 3'd3: return m_lat;
            3'd4: return m_ren;
            3'd5: return m_fen;
            3'd6: return m_st;
            default: return m_alt;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic model_update();
        logic [27:0] ev, wm;
        if (rst) begin
            hist = '{28'h0, 28'h0, 28'h0, 28'h0};
            m_dir = '0; m_lat = '0; m_ren = '0; m_fen = '0; m_st = '0; m_alt = '0;
        end else begin
            ev = (m_ren & hist[1] & ~hist[2]) | (m_fen & ~hist[1] & hist[2]);
            wm = bus_we ? bus_wdata : 28'h0;
            case (bus_addr)
                3'd1: m_dir = bus_we ? bus_wdata : m_dir;
                3'd2: m_lat = m_lat | wm;
                3'd3: m_lat = m_lat & ~wm;
                3'd4: m_ren = bus_we ? bus_wdata : m_ren;
                3'd5: m_fen = bus_we ? bus_wdata : m_fen;
                3'd7: m_alt = bus_we ? bus_wdata : m_alt;
                default: ;
            endcase
            m_st = (m_st & ~((bus_addr == 3'd6) ? wm : 28'h0)) | ev;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    endtask

    task automatic compare_all();
        logic [27:0] hi_grp;
        hi_grp = m_st >> 11;
        check(pin_oe == m_dir, "R3", pin_oe, m_dir);
        check(pin_out == m_lat, "R5", pin_out, m_lat);
        check(altfn == m_alt, "R12", altfn, m_alt);
        check(irq_lo == m_st[10:0], "R10", {17'h0, irq_lo}, {17'h0, m_st[10:0]});
        check(irq_hi == (hi_grp != 0), "R11", {27'h0, irq_hi}, {27'h0, hi_grp != 0});
        check(bus_rdata == model_read(bus_addr), read_tag(bus_addr), bus_rdata,
              model_read(bus_addr));
    endtask

    task automatic step(input logic [2:0] a, input logic we, input logic [27:0] d,
                        input logic [27:0] pins);
        bus_addr = a; bus_we = we; bus_wdata = d; pin_in = pins;
        @(posedge clk);
        #1;
        model_update();
        compare_all();
    endtask

    task automatic rd(input logic [2:0] a, input logic [27:0] exp, input string tag);
        step(a, 1'b0, '0, pin_in);
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%07h expected=%07h", 28'h0, 28'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(3'd0, 1'b0, '0, '0);
        rst = 1'b0;
        // R1 reset state
        check(pin_oe == 0 && pin_out == 0 && altfn == 0, "R1", pin_oe | pin_out | altfn, 0);
        check(irq_lo == 0 && irq_hi == 0, "R1", {16'h0, irq_hi, irq_lo}, 0);
        for (int a = 1; a < 8; a++) rd(a[2:0], 28'h0, "R1");

        // R3 direction, R12 alternate function
        step(3'd1, 1'b1, 28'hFFF0F0F, '0);
        rd(3'd1, 28'hFFF0F0F, "R3");
        check(pin_oe == 28'hFFF0F0F, "R3", pin_oe, 28'hFFF0F0F);
        step(3'd7, 1'b1, 28'h1234567, '0);
        rd(3'd7, 28'h1234567, "R12");
        check(altfn == 28'h1234567, "R12", altfn, 28'h1234567);

        // R4 R5 set and clear
        step(3'd2, 1'b1, 28'h00F0F0F, '0);
        rd(3'd2, 28'h00F0F0F, "R4");
        step(3'd2, 1'b1, 28'h0000000, '0);
        rd(3'd2, 28'h00F0F0F, "R4");
        step(3'd3, 1'b1, 28'h0000F0F, '0);
        rd(3'd3, 28'h00F0000, "R5");
        check(pin_out == 28'h00F0000, "R5", pin_out, 28'h00F0000);

        // R2 level readback and ignored write
        for (int i = 0; i < 3; i++) step(3'd0, 1'b0, '0, 28'h0A5A5A5);
        step(3'd0, 1'b1, 28'hFFFFFFF, 28'h0A5A5A5);
        rd(3'd0, 28'h0A5A5A5, "R2");
        check(pin_out == 28'h00F0000 && pin_oe == 28'hFFF0F0F, "R2", pin_out, 28'h00F0000);
        for (int i = 0; i < 3; i++) step(3'd0, 1'b0, '0, 28'h0);
        step(3'd6, 1'b1, 28'hFFFFFFF, 28'h0);

        // R6 R7 edge detection
        step(3'd4, 1'b1, 28'h010000F, 28'h0);
        step(3'd5, 1'b1, 28'h0000006, 28'h0);
        step(3'd0, 1'b0, '0, 28'h010000F);
        for (int i = 0; i < 3; i++) step(3'd0, 1'b0, '0, 28'h010000F);
        rd(3'd6, 28'h010000F, "R6");
        check(irq_lo == 11'h00F, "R10", {17'h0, irq_lo}, 28'h00F);
        check(irq_hi == 1'b1, "R11", {27'h0, irq_hi}, 28'h1);
        // R8 writing zeros has no effect, ones clear
        step(3'd6, 1'b1, 28'h0000000, 28'h010000F);
        rd(3'd6, 28'h010000F, "R8");
        step(3'd6, 1'b1, 28'h0100001, 28'h010000F);
        rd(3'd6, 28'h000000E, "R8");
        check(irq_hi == 1'b0, "R11", {27'h0, irq_hi}, 28'h0);
        step(3'd6, 1'b1, 28'hFFFFFFF, 28'h010000F);
        for (int i = 0; i < 4; i++) step(3'd0, 1'b0, '0, 28'h0);
        rd(3'd6, 28'h0000006, "R7");

        // R9 clear collides with a new edge on pin 1
        step(3'd0, 1'b0, '0, 28'h0000002);
        step(3'd0, 1'b0, '0, 28'h0000002);
        step(3'd6, 1'b1, 28'h0000006, 28'h0000002);
        rd(3'd6, 28'h0000002, "R9");

        // random traffic compared with the model every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [27:0] p;
            p = pin_in;
            if ($urandom_range(0, 2) == 0) p = p ^ (28'h1 << $urandom_range(0, 27));
            step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 28'($urandom) & 28'($urandom), p);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule